// File: doc/BRIEF.md
# Byte Accumulator Arithmetic Unit with Carry/Borrow Flag

This block is the data path of a small byte-wide processor. It holds an accumulator and a single flag bit that serves as the carry for additions and as the inverted borrow for subtractions. The accumulator is always one operand. The other operand is a byte taken from memory. When the write strobe is high at a rising clock edge, the selected operation runs and its result is written back into the accumulator. Arithmetic operations and the shift also update the flag.

Subtraction is done by adding the one's complement of the subtrahend plus a carry-in. The plain forms force that carry-in to 1. The borrow forms use the current flag as the carry-in. As a result, the flag reads 1 when no borrow happened and 0 when one did. This lets software chain multi-byte additions and subtractions one byte at a time. A zero output follows the accumulator at all times, so a subtraction of two equal bytes doubles as an equality test.

Top module: `acc_alu`

## Requirements
- R1: An active-low reset clears the accumulator to 0x00 and the flag to 0.
- R2: With op 0 (add), the accumulator becomes the low byte of accumulator plus memory byte, and the flag becomes the carry out of bit 7.
- R3: With op 1 (add with carry), the accumulator becomes the low byte of accumulator plus memory byte plus flag, and the flag becomes the carry out of bit 7.
- R4: With op 3, the accumulator becomes accumulator minus memory byte, computed as accumulator + ~memory + 1. The flag becomes 1 when there is no borrow (accumulator ≥ memory) and 0 when there is a borrow.
- R5: With op 2, the accumulator becomes memory byte minus accumulator, computed as memory + ~accumulator + 1. The flag becomes 1 exactly when memory ≥ accumulator.
- R6: With op 4 (memory minus accumulator) and op 5 (accumulator minus memory), the carry-in is the current flag instead of 1. The new flag is the carry out of bit 7.
- R7: Ops 6, 7 and 8 write the bitwise AND, OR and XOR of accumulator and memory byte into the accumulator, and leave the flag unchanged.
- R8: With op 9, the accumulator shifts right by one bit with a 0 entering bit 7, and the flag takes the old bit 0.
- R9: The zero output is high exactly when the accumulator holds 0x00, with no added cycle of delay.
- R10: When the write strobe is low, or when the op is in the range 10 to 15, the accumulator and the flag keep their values.
- R11: Applying op 3 or op 2 with a memory byte equal to the accumulator leaves 0x00 in the accumulator and sets the flag to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation select (codes listed in the requirements) |
| mem_byte | input | 8 | Second operand, from memory |
| wr_en | input | 1 | When high, the selected operation is applied at the clock edge |
| acc | output | 8 | Accumulator contents |
| flag | output | 1 | Carry / inverted-borrow flag |
| zero | output | 1 | High when the accumulator is 0x00 |

## Verification
All state is the accumulator and the flag, and both are direct outputs. A wrong carry-in choice or a wrong operand order therefore appears on `acc` and `flag` in the cycle right after the strobed edge. A flag that is lost or corrupted shows up one operation later, in the result of an add-with-carry or a subtract-with-borrow. The bench loads each operand pair and flag value through the normal operations and then checks a single strobed operation against an independent model. This covers both flag values and the all-zeros and all-ones corners.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op,
  input  logic [W-1:0] mem_byte,
  input  logic         wr_en,
  output logic [W-1:0] acc,
  output logic         flag,
  output logic         zero
);
  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADC  = 4'd1;
  localparam logic [3:0] OP_SUBM = 4'd2;
  localparam logic [3:0] OP_SUBD = 4'd3;
  localparam logic [3:0] OP_SBM  = 4'd4;
  localparam logic [3:0] OP_SBD  = 4'd5;
  localparam logic [3:0] OP_AND  = 4'd6;
  localparam logic [3:0] OP_OR   = 4'd7;
  localparam logic [3:0] OP_XOR  = 4'd8;
  localparam logic [3:0] OP_SHR  = 4'd9;

  logic [W-1:0] opa, opb, nxt_d;
  logic         cin, nxt_f, upd;
  logic [W:0]   sum;

  always_comb begin
    opa = acc;
    opb = mem_byte;
    cin = 1'b0;
    case (op)
      OP_ADC:  cin = flag;
      OP_SUBM: begin opa = mem_byte; opb = ~acc;     cin = 1'b1; end
      OP_SUBD: begin opa = acc;      opb = ~mem_byte; cin = 1'b1; end
      OP_SBM:  begin opa = mem_byte; opb = ~acc;     cin = flag; end
      OP_SBD:  begin opa = acc;      opb = ~mem_byte; cin = flag; end
      default: ;
    endcase
  end

  assign sum = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin};

  always_comb begin
    nxt_d = acc;
    nxt_f = flag;
    upd   = 1'b1;
    case (op)
      OP_ADD, OP_ADC, OP_SUBM, OP_SUBD, OP_SBM, OP_SBD: begin
        nxt_d = sum[W-1:0];
        nxt_f = sum[W];
      end
      OP_AND:  nxt_d = acc & mem_byte;
      OP_OR:   nxt_d = acc | mem_byte;
      OP_XOR:  nxt_d = acc ^ mem_byte;
      OP_SHR:  begin nxt_d = {1'b0, acc[W-1:1]}; nxt_f = acc[0]; end
      default: upd = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      flag <= 1'b0;
    end else if (wr_en && upd) begin
      acc  <= nxt_d;
      flag <= nxt_f;
    end
  end

  assign zero = (acc == '0);
endmodule

module acc_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op,
  input logic [W-1:0] mem_byte,
  input logic         wr_en,
  input logic [W-1:0] acc,
  input logic         flag,
  input logic         zero
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (acc == '0 && !flag));

  p_add_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == 4'd0) |=>
      ({flag, acc} == ({1'b0, $past(acc)} + {1'b0, $past(mem_byte)})));

  p_logic_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (op == 4'd6 || op == 4'd7 || op == 4'd8)) |=> (flag == $past(flag)));

  p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == 4'd9) |=> (acc == ($past(acc) >> 1) && flag == $past(acc[0])));

  p_zero_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == 4'd6 && mem_byte == '0) |=> zero);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || op > 4'd9) |=> ($stable(acc) && $stable(flag)));

  p_equal_test_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == 4'd3 && mem_byte == acc) |=> (zero && flag));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (.*);

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] mem_byte = '0;
  logic       wr_en = 1'b0;
  logic [7:0] acc;
  logic       flag, zero;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  acc_alu dut (.clk(clk), .rst_n(rst_n), .op(op), .mem_byte(mem_byte),
               .wr_en(wr_en), .acc(acc), .flag(flag), .zero(zero));

  function automatic logic [8:0] model(input logic [3:0] o, input logic [7:0] d,
                                       input logic [7:0] m, input logic f);
    case (o)
      4'd0: return {1'b0, d} + {1'b0, m};
      4'd1: return {1'b0, d} + {1'b0, m} + {8'd0, f};
      4'd2: return {1'b0, m} + {1'b0, ~d} + 9'd1;
      4'd3: return {1'b0, d} + {1'b0, ~m} + 9'd1;
      4'd4: return {1'b0, m} + {1'b0, ~d} + {8'd0, f};
      4'd5: return {1'b0, d} + {1'b0, ~m} + {8'd0, f};
      4'd6: return {f, d & m};
      4'd7: return {f, d | m};
      4'd8: return {f, d ^ m};
      4'd9: return {d[0], 1'b0, d[7:1]};
      default: return {f, d};
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] ed, input logic ef);
    n_chk++;
    if (acc !== ed || flag !== ef || zero !== (ed == 8'h00)) begin
      n_bad++;
      $display("FAIL %s: acc=%h flag=%b zero=%b expected acc=%h flag=%b zero=%b",
               req, acc, flag, zero, ed, ef, (ed == 8'h00));
    end
  endtask

  task automatic step(input logic [3:0] o, input logic [7:0] m, input logic we = 1'b1);
    @(negedge clk);
    op = o; mem_byte = m; wr_en = we;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [7:0] a, input logic f);
    step(4'd6, 8'h00);
    step(4'd0, f ? 8'hFF : 8'h00);
    if (f) step(4'd0, 8'h01);
    step(4'd7, a);
  endtask

  task automatic run_one(input string req, input logic [3:0] o, input logic [7:0] a,
                         input logic [7:0] m, input logic f);
    logic [8:0] e;
    load(a, f);
    e = model(o, a, m, f);
    step(o, m);
    check(req, e[7:0], e[8]);
  endtask

  task automatic t_reset_r1;
    @(negedge clk);
    check("R1 reset", 8'h00, 1'b0);
  endtask

  task automatic t_corners;
    logic [7:0] vals [4] = '{8'h00, 8'hFF, 8'h01, 8'h80};
    for (int o = 0; o < 10; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int f = 0; f < 2; f++)
            run_one(o < 2 ? "R2/R3 add corner" : o < 4 ? "R4/R5 sub corner" :
                    o < 6 ? "R6 borrow corner" : o < 9 ? "R7 logic corner" : "R8 shift corner",
                    4'(o), vals[i], vals[j], f[0]);
  endtask

  task automatic t_random;
    for (int k = 0; k < 400; k++) begin
      logic [3:0] o = 4'($urandom_range(0, 9));
      run_one("R2-R8 random op R9 zero", o, 8'($urandom), 8'($urandom), 1'($urandom));
    end
  endtask

  task automatic t_chain_r3;
    load(8'hF0, 1'b0);
    step(4'd0, 8'h20);
    check("R2 low byte carry", 8'h10, 1'b1);
    load(8'h01, 1'b1);
    step(4'd1, 8'h00);
    check("R3 high byte with carry", 8'h02, 1'b0);
  endtask

  task automatic t_borrow_r6;
    load(8'h10, 1'b0);
    step(4'd5, 8'h01);
    check("R6 D-M with borrow", 8'h0E, 1'b1);
    load(8'h05, 1'b0);
    step(4'd4, 8'h05);
    check("R6 M-D with borrow", 8'hFF, 1'b0);
  endtask

  task automatic t_hold_r10;
    load(8'h5A, 1'b1);
    step(4'd0, 8'h33, 1'b0);
    check("R10 strobe low", 8'h5A, 1'b1);
    for (int o = 10; o < 16; o++) begin
      step(4'(o), 8'hC3);
      check("R10 unused op", 8'h5A, 1'b1);
    end
  endtask

  task automatic t_equal_r11;
    load(8'hA7, 1'b0);
    step(4'd3, 8'hA7);
    check("R11 equal via op3", 8'h00, 1'b1);
    load(8'h3C, 1'b0);
    step(4'd2, 8'h3C);
    check("R11 equal via op2", 8'h00, 1'b1);
  endtask

  task automatic t_shift_chain_r8;
    load(8'h05, 1'b0);
    step(4'd9, 8'h00);
    check("R8 shift bit0=1", 8'h02, 1'b1);
    step(4'd9, 8'h00);
    check("R8 shift bit0=0", 8'h01, 1'b0);
    step(4'd9, 8'h00);
    check("R8 shift to zero R9", 8'h00, 1'b1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    t_reset_r1();
    t_chain_r3();
    t_borrow_r6();
    t_shift_chain_r8();
    t_equal_r11();
    t_hold_r10();
    t_corners();
    t_random();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=finished");
    finish_run();
  end
endmodule